// File: doc/BRIEF.md
# Operand-Handshake Integer Computation Unit

This block carries one 16-bit integer operation from the moment it is issued until its result has been written back. When `issue_i` is seen high while the unit is idle, it captures an operation descriptor: the opcode, the invert-A flag, the zero-A flag, an immediate value and its valid bit. It also captures a per-port read mask. The unit then raises a read request on every source port whose operand must come from a register. Each request stays up until a one-cycle grant arrives with the operand on the source bus.

Once every needed operand is in, a small internal ALU computes the result. The ALU does pass-through (NOP) and 16-bit addition, with optional bitwise inversion of operand A. The unit then raises a write request. It stays busy until a one-cycle write grant confirms that the result was stored, and accepts the next operation in the cycle after that grant. An issuer uses `busy_o` to know when the unit is free. It answers each `rd_req_o` bit with a `rd_gnt_i` pulse, which may be given combinationally in the same cycle the request is seen. It answers `wr_req_o` with a `wr_gnt_i` pulse, while the result is on `result_o`.

Top module: `opunit_core`

## Requirements
- R1: `busy_o` goes high in the cycle after an issue is accepted. It stays high until the cycle after `wr_gnt_i` is seen with `wr_req_o` high. While idle with `issue_i` low, `busy_o` never rises.
- R2: In the cycle where an idle unit samples `issue_i` high, `busy_o` is still low.
- R3: All descriptor fields (`op_i`, `inv_a_i`, `zero_a_i`, `imm_i`, `imm_vld_i`) and `rd_mask_i` are captured in the accepting cycle. Changing or clearing them afterwards does not change the result.
- R4: After an accepted issue, each needed port's `rd_req_o` bit rises in the next cycle. It stays high for any number of cycles until that port's `rd_gnt_i` bit is seen high.
- R5: A grant may come in the same cycle as its request. In that cycle `alu_opnd_o[i]` equals `src_i[i]`, and `rd_req_o[i]` is low in the next cycle.
- R6: With `imm_vld_i` set, operand B (port 1) takes `imm_i` and `rd_req_o[1]` never rises. With `zero_a_i` set, operand A (port 0) is zero and `rd_req_o[0]` never rises.
- R7: `rd_mask_i[0]` set suppresses the port-0 request, and `rd_mask_i[1]` set suppresses the port-1 request. A suppressed operand reads as zero unless R6 supplies the immediate.
- R8: The ALU first forms A' = `inv_a` ? ~A : A. Opcode value 1 (ADD) gives (A' + B) mod 2^16. Opcode 0 and every other code (NOP) give A'.
- R9: When the result is ready, `wr_req_o` is held high until `wr_gnt_i` is seen. `result_o` holds the result, unchanged, for as long as `wr_req_o` is high.
- R10: In the cycle after the write grant, `busy_o`, `rd_req_o` and `wr_req_o` are all low, and an issue in that cycle is accepted.
- R11: `issue_i` raised while `busy_o` is high is ignored. The operation in progress and its result are unchanged.
- R12: With every grant given without delay, the whole operation (issue to `busy_o` low) takes no more than 50 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | Start an operation (accepted only when idle) |
| op_i | input | 2 | Opcode: 0 NOP, 1 ADD, others NOP |
| inv_a_i | input | 1 | Bitwise-invert operand A before use |
| zero_a_i | input | 1 | Force operand A to zero, no port-0 read |
| imm_i | input | DATA_W | Immediate value for operand B |
| imm_vld_i | input | 1 | Use the immediate as operand B, no port-1 read |
| rd_mask_i | input | 2 | Per-port read suppression, bit 0 = A, bit 1 = B |
| src_i | input | 2 x DATA_W | Operand buses, index 0 = A, 1 = B |
| rd_gnt_i | input | 2 | Per-port read grant pulses |
| rd_req_o | output | 2 | Per-port read requests |
| alu_opnd_o | output | 2 x DATA_W | Operands presented to the ALU (with same-cycle forwarding) |
| wr_req_o | output | 1 | Write request, result ready |
| wr_gnt_i | input | 1 | Write grant pulse |
| result_o | output | DATA_W | ALU result |
| busy_o | output | 1 | Unit occupied |

## Verification
If the control state is wrong, it shows at the ports within a cycle. `busy_o`, `rd_req_o` or `wr_req_o` then disagree with the reference model at the next comparison, because every one of them is a direct function of the phase and the request flags. A wrong operand latch or a wrong ALU path stays hidden until the write request. It then shows as a wrong `result_o` in the first write-request cycle, and a forwarding fault shows on `alu_opnd_o` in the very grant cycle. Stalled grants, a spurious issue while busy and descriptor inputs cleared right after issue show whether captured state leaks from the live inputs.

// File: rtl/opu_pkg.sv
package opu_pkg;

    localparam int OPC_W  = 2;
    localparam int N_SRC  = 2;
    localparam int SRC_A  = 0;
    localparam int SRC_B  = 1;

    typedef enum logic [OPC_W-1:0] {
        OPC_NOP = 2'd0,
        OPC_ADD = 2'd1,
        OPC_RS2 = 2'd2,
        OPC_RS3 = 2'd3
    } opu_op_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } opu_phase_e;

    typedef struct packed {
        opu_op_e op;
        logic    inv_a;
        logic    zero_a;
        logic    imm_vld;
    } opu_desc_t;

    function automatic logic [N_SRC-1:0] need_mask(input opu_desc_t d,
                                                   input logic [N_SRC-1:0] msk);
        logic [N_SRC-1:0] n;
        n[SRC_A] = !d.zero_a  && !msk[SRC_A];
        n[SRC_B] = !d.imm_vld && !msk[SRC_B];
        return n;
    endfunction

endpackage

// File: rtl/opu_src_port.sv
module opu_src_port #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         need_i,
    input  logic [W-1:0] init_i,
    input  logic         gnt_i,
    input  logic [W-1:0] src_i,
    output logic         req_o,
    output logic [W-1:0] opnd_o
);
    logic         req_q;
    logic [W-1:0] held_q;
    logic         take;

    assign take = req_q && gnt_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            held_q <= '0;
        end else if (load_i) begin
            req_q  <= need_i;
            held_q <= init_i;
        end else if (take) begin
            req_q  <= 1'b0;
            held_q <= src_i;
        end
    end

    assign req_o  = req_q;
    assign opnd_o = take ? src_i : held_q;
endmodule

// File: rtl/opu_alu.sv
module opu_alu
    import opu_pkg::*;
#(
    parameter int W = 16
) (
    input  opu_op_e      op_i,
    input  logic         inv_a_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    logic [W-1:0] a_eff;

    assign a_eff = inv_a_i ? ~a_i : a_i;

    always_comb begin
        case (op_i)
            OPC_ADD: y_o = a_eff + b_i;
            default: y_o = a_eff;
        endcase
    end
endmodule

// File: rtl/opu_ctrl.sv
module opu_ctrl
    import opu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic issue_i,
    input  logic pend_next_i,
    input  logic wr_gnt_i,
    output logic accept_o,
    output logic capture_o,
    output logic busy_o,
    output logic wr_req_o
);
    opu_phase_e ph_q, ph_d;

    assign accept_o  = (ph_q == PH_IDLE) && issue_i;
    assign capture_o = (ph_q == PH_READ) && !pend_next_i;

    always_comb begin
        ph_d = ph_q;
        case (ph_q)
            PH_IDLE:  if (issue_i)      ph_d = PH_READ;
            PH_READ:  if (!pend_next_i) ph_d = PH_WRITE;
            PH_WRITE: if (wr_gnt_i)     ph_d = PH_IDLE;
            default:                    ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_IDLE;
        else     ph_q <= ph_d;
    end

    assign busy_o   = (ph_q != PH_IDLE);
    assign wr_req_o = (ph_q == PH_WRITE);
endmodule

// File: rtl/opunit_core.sv
module opunit_core
    import opu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          issue_i,
    input  logic [1:0]                    op_i,
    input  logic                          inv_a_i,
    input  logic                          zero_a_i,
    input  logic [DATA_W-1:0]             imm_i,
    input  logic                          imm_vld_i,
    input  logic [1:0]                    rd_mask_i,
    input  logic [1:0][DATA_W-1:0]        src_i,
    input  logic [1:0]                    rd_gnt_i,
    output logic [1:0]                    rd_req_o,
    output logic [1:0][DATA_W-1:0]        alu_opnd_o,
    output logic                          wr_req_o,
    input  logic                          wr_gnt_i,
    output logic [DATA_W-1:0]             result_o,
    output logic                          busy_o
);
    opu_desc_t                   desc_in, desc_q;
    logic                        accept, capture, pend_next;
    logic [N_SRC-1:0]            need;
    logic [N_SRC-1:0][DATA_W-1:0] init_val;
    logic [DATA_W-1:0]           alu_y;
    logic [DATA_W-1:0]           result_q;

    assign desc_in.op      = opu_op_e'(op_i);
    assign desc_in.inv_a   = inv_a_i;
    assign desc_in.zero_a  = zero_a_i;
    assign desc_in.imm_vld = imm_vld_i;

    assign need              = need_mask(desc_in, rd_mask_i);
    assign init_val[SRC_A]   = '0;
    assign init_val[SRC_B]   = imm_vld_i ? imm_i : '0;
    assign pend_next         = |(rd_req_o & ~rd_gnt_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            desc_q   <= '0;
            result_q <= '0;
        end else begin
            if (accept)  desc_q   <= desc_in;
            if (capture) result_q <= alu_y;
        end
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_port
        opu_src_port #(.W(DATA_W)) u_port (
            .clk    (clk),
            .rst    (rst),
            .load_i (accept),
            .need_i (need[i]),
            .init_i (init_val[i]),
            .gnt_i  (rd_gnt_i[i]),
            .src_i  (src_i[i]),
            .req_o  (rd_req_o[i]),
            .opnd_o (alu_opnd_o[i])
        );
    end

    opu_alu #(.W(DATA_W)) u_alu (
        .op_i    (desc_q.op),
        .inv_a_i (desc_q.inv_a),
        .a_i     (alu_opnd_o[SRC_A]),
        .b_i     (alu_opnd_o[SRC_B]),
        .y_o     (alu_y)
    );

    opu_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .issue_i     (issue_i),
        .pend_next_i (pend_next),
        .wr_gnt_i    (wr_gnt_i),
        .accept_o    (accept),
        .capture_o   (capture),
        .busy_o      (busy_o),
        .wr_req_o    (wr_req_o)
    );

    assign result_o = result_q;
endmodule

// File: rtl/opunit_core_chk.sv
module opunit_core_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              issue_i,
    input logic [1:0]        rd_gnt_i,
    input logic [1:0]        rd_req_o,
    input logic              wr_req_o,
    input logic              wr_gnt_i,
    input logic [DATA_W-1:0] result_o,
    input logic              busy_o
);
    assert_busy_rise_R1: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && issue_i) |=> busy_o);

    assert_no_self_rise_R1: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !issue_i) |=> !busy_o);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (rd_req_o == 2'b00) && !wr_req_o);

    for (genvar i = 0; i < 2; i++) begin : g_rd
        assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
            (rd_req_o[i] && !rd_gnt_i[i]) |=> rd_req_o[i]);
        assert_req_drop_R5: assert property (@(posedge clk) disable iff (rst)
            (rd_req_o[i] && rd_gnt_i[i]) |=> !rd_req_o[i]);
    end

    assert_wr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_req_o && !wr_gnt_i) |=> wr_req_o && $stable(result_o));

    assert_no_rd_in_write_R9: assert property (@(posedge clk) disable iff (rst)
        wr_req_o |-> (rd_req_o == 2'b00));

    assert_release_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_req_o && wr_gnt_i) |=> !busy_o && !wr_req_o && (rd_req_o == 2'b00));
endmodule

bind opunit_core opunit_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .issue_i  (issue_i),
    .rd_gnt_i (rd_gnt_i),
    .rd_req_o (rd_req_o),
    .wr_req_o (wr_req_o),
    .wr_gnt_i (wr_gnt_i),
    .result_o (result_o),
    .busy_o   (busy_o)
);

// File: tb/opunit_core_test.sv
`timescale 1ns/1ps
module opunit_core_test;
    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             issue = 1'b0;
    logic [1:0]       opc = 2'd0;
    logic             inva = 1'b0, zera = 1'b0, immv = 1'b0;
    logic [15:0]      imm = '0;
    logic [1:0]       mask = '0;
    logic [1:0][15:0] src = '0;
    logic [1:0]       gnt = '0;
    logic             wgnt = 1'b0;
    logic [1:0]       rd_req;
    logic [1:0][15:0] opnd;
    logic             wr_req, busy;
    logic [15:0]      result;

    int tests = 0, fails = 0;

    always #5 clk = ~clk;

    opunit_core #(.DATA_W(16)) uut (
        .clk(clk), .rst(rst), .issue_i(issue), .op_i(opc), .inv_a_i(inva),
        .zero_a_i(zera), .imm_i(imm), .imm_vld_i(immv), .rd_mask_i(mask),
        .src_i(src), .rd_gnt_i(gnt), .rd_req_o(rd_req), .alu_opnd_o(opnd),
        .wr_req_o(wr_req), .wr_gnt_i(wgnt), .result_o(result), .busy_o(busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model, phase 0 idle, 1 reading, 2 writing
    int          m_ph = 0;
    bit [1:0]    m_req = '0;
    int          m_val[2];
    int          m_op = 0;
    bit          m_inv = 0;
    int          m_res = 0;

    function automatic int alu_ref(int op, bit inv, int a, int b);
        int ae = inv ? (~a & 16'hFFFF) : (a & 16'hFFFF);
        return (op == 1) ? ((ae + b) & 16'hFFFF) : ae;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_req = '0;
        end else begin
            case (m_ph)
                0: if (issue) begin
                    m_op = opc; m_inv = inva;
                    m_val[0] = 0;
                    m_val[1] = immv ? int'(imm) : 0;
                    m_req[0] = !zera && !mask[0];
                    m_req[1] = !immv && !mask[1];
                    m_ph = 1;
                end
                1: begin
                    for (int i = 0; i < 2; i++)
                        if (m_req[i] && gnt[i]) begin
                            m_val[i] = int'(src[i]); m_req[i] = 0;
                        end
                    if (m_req == 2'b00) begin
                        m_res = alu_ref(m_op, m_inv, m_val[0], m_val[1]);
                        m_ph = 2;
                    end
                end
                default: if (wgnt) m_ph = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(busy == (m_ph != 0), "R1 busy vs model", busy, m_ph != 0);
            chk(rd_req == m_req, "R4 rd_req vs model", rd_req, m_req);
            chk(wr_req == (m_ph == 2), "R9 wr_req vs model", wr_req, m_ph == 2);
            if (m_ph == 2)
                chk(result == m_res[15:0], "R8 result vs model", result, m_res);
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic run_op(input int a, input int b, input int op, input bit inv,
                          input bit zero, input int im, input bit iv,
                          input bit [1:0] mk, input int dly_a, input int dly_b,
                          input int dly_w, input bit spur, input int exp,
                          input string tag);
        int val[2];
        int dly[2];
        int waited[2];
        int wwait = 0;
        int cycles = 0;
        val[0] = a; val[1] = b; dly[0] = dly_a; dly[1] = dly_b;
        waited[0] = 0; waited[1] = 0;
        issue = 1; opc = op[1:0]; inva = inv; zera = zero;
        imm = im[15:0]; immv = iv; mask = mk;
        #1 chk(busy == 0, "R2 busy low in issue cycle", busy, 0);
        tick();
        // R3: clear the descriptor right after the issue cycle
        issue = 0; opc = 2'd0; inva = 0; zera = 0; imm = 16'h5A5A; immv = 0;
        for (int k = 0; k < 200; k++) begin
            gnt = '0; wgnt = 0; src = '0; issue = 0;
            if (spur && k == 0) begin
                issue = 1; opc = 2'd0; inva = 1; zera = 1;
            end
            for (int i = 0; i < 2; i++)
                if (rd_req[i]) begin
                    if (waited[i] >= dly[i]) begin
                        gnt[i] = 1; src[i] = val[i][15:0];
                    end else waited[i]++;
                end
            if (wr_req) begin
                if (wwait >= dly_w) wgnt = 1;
                else wwait++;
            end
            #1;
            for (int i = 0; i < 2; i++)
                if (gnt[i])
                    chk(opnd[i] == val[i][15:0], "R5 same-cycle forward", opnd[i], val[i]);
            if (wgnt)
                chk(result == exp[15:0], tag, result, exp);
            tick();
            cycles++;
            if (!busy) break;
        end
        gnt = '0; wgnt = 0; src = '0; issue = 0; zera = 0; inva = 0;
        chk(rd_req == 2'b00 && !wr_req && !busy, "R10 all low after write grant",
            {rd_req, wr_req, busy}, 0);
        if (dly_a == 0 && dly_b == 0 && dly_w == 0)
            chk(cycles + 1 <= 50, "R12 latency bound", cycles + 1, 50);
        mask = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        chk(busy == 0 && rd_req == 0 && wr_req == 0, "R1 reset state", busy, 0);
        repeat (4) begin
            tick();
            chk(busy == 0, "R1 no self rise", busy, 0);
        end
        run_op(5, 2, 1, 0, 0, 8, 1, 2'b00, 0, 0, 0, 0, 13, "R6 ADD with immediate");
        run_op(5, 2, 1, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0, 7,  "R8 ADD plain");
        run_op(5, 2, 1, 1, 0, 0, 0, 2'b00, 0, 0, 0, 0, 65532, "R8 ADD invert A");
        run_op(5, 2, 1, 0, 1, 8, 1, 2'b00, 0, 0, 0, 0, 8,  "R6 zero A with immediate");
        run_op(5, 2, 1, 0, 1, 0, 0, 2'b00, 0, 0, 0, 0, 2,  "R6 zero A");
        run_op(5, 2, 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0, 5,  "R8 NOP pass-through");
        run_op(9, 2, 0, 0, 0, 8, 1, 2'b00, 0, 0, 0, 0, 9,  "R8 NOP with immediate");
        run_op(5, 2, 1, 0, 0, 0, 0, 2'b01, 0, 0, 0, 0, 2,  "R7 mask port A");
        run_op(5, 2, 1, 0, 0, 0, 0, 2'b10, 0, 0, 0, 0, 5,  "R7 mask port B");
        run_op(5, 2, 1, 0, 0, 0, 0, 2'b11, 0, 0, 0, 0, 0,  "R7 mask both");
        run_op(5, 2, 1, 0, 0, 0, 0, 2'b00, 0, 3, 0, 0, 7,  "R4 delayed grant B");
        run_op(7, 6, 1, 0, 0, 0, 0, 2'b00, 4, 1, 3, 0, 13, "R9 delayed grants and write");
        run_op(65535, 2, 1, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0, 1, "R8 ADD wraps");
        run_op(3, 4, 1, 0, 0, 0, 0, 2'b00, 2, 2, 1, 1, 7, "R11 issue while busy ignored");
        run_op(5, 2, 3, 1, 0, 0, 0, 2'b00, 0, 0, 0, 0, 65530, "R8 other opcode is NOP");
        // R3: fields were cleared after every issue above; one more with immediate cleared later
        run_op(100, 0, 1, 0, 0, 23, 1, 2'b00, 0, 0, 2, 0, 123, "R3 fields captured at issue");
        tick();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule